// File: doc/BRIEF.md
# Multi-Thread Retire Slot Arbiter

This block decides, for each retire slot of a multithreaded out-of-order core, which hardware thread may retire the instruction at the head of its reorder buffer. For every thread it takes a status code, a head-ready flag, a buffer-empty flag and the sequence number of the head instruction. From these it produces a valid flag and a thread index in the same cycle. The retire logic around it consumes the grant and pulses a fire input when the retirement really takes place.

The selection rule is chosen at run time and can change from one cycle to the next. A fair mode keeps an ordered list of thread IDs in registers. The winning thread moves to the back of that list, but only on a fired grant. An age mode lets the thread with the oldest ready head instruction win. A third setting uses the age rule as well. When the block is built for one thread, that thread is granted on its status alone.

Top module: `commit_thread_select`

## Requirements
- R1: `policySel` encodes the rule: 0 = aggressive (same rule as oldest-ready), 1 = round-robin, 2 = oldest-ready, 3 = reserved. The reserved setting never produces a grant.
- R2: Each thread's 3-bit status field sits at bits [3t+2:3t] of `threadStatus`. Codes 0 (running), 1 (idle) and 2 (fetch-trap pending) make the thread eligible. Codes 3 (trap pending), 4 (buffer squashing) and 5 to 7 make it ineligible.
- R3: In round-robin mode the priority list is scanned from front to back. The first thread that is eligible and has `headReady` set is granted.
- R4: When `retireFire` is high at a clock edge with a valid round-robin grant, the granted thread is removed from its place in the list and appended at the tail. The other threads keep their relative order. In every other case the list is left unchanged.
- R5: In oldest-ready and aggressive modes, only threads that are eligible, head-ready and non-empty are candidates. The candidate whose `headSeq` field (bits [16t+15:16t]) is smallest wins. Sequence numbers are compared only with each other, and a tie goes to the lower thread ID.
- R6: With a thread count of 1, thread 0 is granted in every non-reserved mode whenever its status is eligible, regardless of `headReady` and `robEmpty`.
- R7: After reset the priority list holds the thread IDs in ascending order, with thread 0 at the front.
- R8: When no thread qualifies, `grantValid` is 0 and `grantTid` is 0.
- R9: The grant is combinational: it reflects the inputs of the current cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | Selection rule (R1) |
| threadStatus | input | 3*NUM_THREADS | Per-thread status codes |
| headReady | input | NUM_THREADS | Head instruction ready to retire |
| robEmpty | input | NUM_THREADS | Thread's reorder buffer is empty |
| headSeq | input | SEQ_W*NUM_THREADS | Head sequence number per thread |
| retireFire | input | 1 | The current grant is consumed this cycle |
| grantValid | output | 1 | A thread is selected |
| grantTid | output | TID_W | Selected thread index |

## Verification
Round-robin is driven with all threads ready while fires are pulsed, which shows the list rotating. It is then driven with the fire held low, which shows the list staying put, and with only some threads ready, which shows the scan skipping to later entries. The age rule is given sequence numbers that run against thread order and sequence numbers that tie. This separates a true sequence comparison from a thread-index or last-wins comparison. Each status code and the reserved setting are applied one at a time to prove the eligibility filter. A one-thread instance receives a not-ready, empty thread to show the status-only grant. A long pseudo-random mix of all inputs is then checked against the reference model on every cycle.

// File: rtl/commit_sel_pkg.sv
package commit_sel_pkg;

  localparam int STATUS_W = 3;

  typedef enum logic [STATUS_W-1:0] {
    ST_RUNNING    = 3'd0,
    ST_IDLE       = 3'd1,
    ST_FETCH_TRAP = 3'd2,
    ST_TRAP       = 3'd3,
    ST_SQUASHING  = 3'd4
  } thrStatus_e;

  typedef enum logic [1:0] {
    POL_AGGRESSIVE = 2'd0,
    POL_ROUND      = 2'd1,
    POL_OLDEST     = 2'd2,
    POL_RESERVED   = 2'd3
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useRound;
    logic useOldest;
    logic singleMode;
  } selStrobe_t;

  function automatic logic statusEligible(input logic [STATUS_W-1:0] code);
    return (code == ST_RUNNING) || (code == ST_IDLE) || (code == ST_FETCH_TRAP);
  endfunction

endpackage

// File: rtl/commit_sel_ctrl.sv
module commit_sel_ctrl
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   policySel,
  input  logic                         retireFire,
  input  logic                         grantValid,
  input  logic [TID_W-1:0]             grantPos,
  output selStrobe_t                   strobes,
  output logic [NUM_THREADS*TID_W-1:0] prioFlat
);

  logic [TID_W-1:0] prioList [NUM_THREADS];

  // policy decode
  always_comb begin
    strobes = '0;
    if (NUM_THREADS == 1) begin
      strobes.singleMode = (policySel != POL_RESERVED);
    end else begin
      strobes.useRound  = (policySel == POL_ROUND);
      strobes.useOldest = (policySel == POL_AGGRESSIVE) || (policySel == POL_OLDEST);
    end
  end

  generate
    if (NUM_THREADS == 1) begin : gSingle
      logic unusedRotate;
      assign unusedRotate = ^{retireFire, grantValid, grantPos};
      always_ff @(posedge clk) begin
        prioList[0] <= '0;
      end
    end else begin : gMulti
      logic rotateNow;
      assign rotateNow = strobes.useRound && grantValid && retireFire;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < NUM_THREADS; i++) prioList[i] <= TID_W'(i);
        end else if (rotateNow) begin
          for (int i = 0; i < NUM_THREADS - 1; i++) begin
            if (i >= int'(grantPos)) prioList[i] <= prioList[i+1];
          end
          prioList[NUM_THREADS-1] <= prioList[grantPos];
        end
      end
    end
  endgenerate

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gPack
    assign prioFlat[g*TID_W +: TID_W] = prioList[g];
  end

endmodule

// File: rtl/commit_sel_dp.sv
module commit_sel_dp
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input  selStrobe_t                      strobes,
  input  logic [NUM_THREADS*STATUS_W-1:0] threadStatus,
  input  logic [NUM_THREADS-1:0]          headReady,
  input  logic [NUM_THREADS-1:0]          robEmpty,
  input  logic [NUM_THREADS*SEQ_W-1:0]    headSeq,
  input  logic [NUM_THREADS*TID_W-1:0]    prioFlat,
  output logic                            grantValid,
  output logic [TID_W-1:0]                grantTid,
  output logic [TID_W-1:0]                grantPos
);

  logic [NUM_THREADS-1:0] eligible, roundQual, oldQual;
  logic                   roundHit, oldHit;
  logic [TID_W-1:0]       roundTid, roundPos, oldTid;
  logic [SEQ_W-1:0]       oldSeq;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      eligible[t]  = statusEligible(threadStatus[t*STATUS_W +: STATUS_W]);
      roundQual[t] = eligible[t] && headReady[t];
      oldQual[t]   = eligible[t] && headReady[t] && !robEmpty[t];
    end
  end

  // list scan: walk back to front so the front-most hit remains
  always_comb begin
    logic [TID_W-1:0] id;
    roundHit = 1'b0;
    roundTid = '0;
    roundPos = '0;
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      id = prioFlat[i*TID_W +: TID_W];
      if (int'(id) < NUM_THREADS && roundQual[id]) begin
        roundHit = 1'b1;
        roundTid = id;
        roundPos = TID_W'(i);
      end
    end
  end

  // age compare: strict less-than keeps the lower ID on a tie
  always_comb begin
    oldHit = 1'b0;
    oldTid = '0;
    oldSeq = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (oldQual[t] && (!oldHit || headSeq[t*SEQ_W +: SEQ_W] < oldSeq)) begin
        oldHit = 1'b1;
        oldTid = TID_W'(t);
        oldSeq = headSeq[t*SEQ_W +: SEQ_W];
      end
    end
  end

  always_comb begin
    grantValid = 1'b0;
    grantTid   = '0;
    grantPos   = '0;
    if (strobes.singleMode) begin
      grantValid = eligible[0];
    end else if (strobes.useRound) begin
      grantValid = roundHit;
      grantTid   = roundTid;
      grantPos   = roundPos;
    end else if (strobes.useOldest) begin
      grantValid = oldHit;
      grantTid   = oldTid;
    end
  end

endmodule

// File: rtl/commit_thread_select.sv
module commit_thread_select
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [1:0]                      policySel,
  input  logic [NUM_THREADS*STATUS_W-1:0] threadStatus,
  input  logic [NUM_THREADS-1:0]          headReady,
  input  logic [NUM_THREADS-1:0]          robEmpty,
  input  logic [NUM_THREADS*SEQ_W-1:0]    headSeq,
  input  logic                            retireFire,
  output logic                            grantValid,
  output logic [TID_W-1:0]                grantTid
);

  selStrobe_t                   strobes;
  logic [NUM_THREADS*TID_W-1:0] prioFlat;
  logic [TID_W-1:0]             grantPos;

  commit_sel_ctrl #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .policySel(policySel), .retireFire(retireFire),
    .grantValid(grantValid), .grantPos(grantPos),
    .strobes(strobes), .prioFlat(prioFlat)
  );

  commit_sel_dp #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_dp (
    .strobes(strobes), .threadStatus(threadStatus), .headReady(headReady),
    .robEmpty(robEmpty), .headSeq(headSeq), .prioFlat(prioFlat),
    .grantValid(grantValid), .grantTid(grantTid), .grantPos(grantPos)
  );

endmodule

// File: rtl/commit_sel_chk.sv
module commit_sel_chk
  import commit_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 2
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [1:0]                      policySel,
  input logic [NUM_THREADS*STATUS_W-1:0] threadStatus,
  input logic [NUM_THREADS-1:0]          headReady,
  input logic [NUM_THREADS-1:0]          robEmpty,
  input logic [NUM_THREADS*SEQ_W-1:0]    headSeq,
  input logic                            retireFire,
  input logic                            grantValid,
  input logic [TID_W-1:0]                grantTid
);

  // R2
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (threadStatus[STATUS_W*grantTid +: STATUS_W] <= 3'd2));

  // R1
  reserved_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (policySel == 2'd3) |-> !grantValid);

  // R8
  idle_tid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantTid == '0));

  // R3
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_THREADS > 1 && grantValid) |-> headReady[grantTid]);

  // R5
  oldest_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_THREADS > 1 && grantValid && policySel != 2'd1) |-> !robEmpty[grantTid]);

  // R9
  tid_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (int'(grantTid) < NUM_THREADS));

  logic unusedChk;
  assign unusedChk = ^{headSeq, retireFire};

endmodule

bind commit_thread_select commit_sel_chk #(
  .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .policySel(policySel), .threadStatus(threadStatus),
  .headReady(headReady), .robEmpty(robEmpty), .headSeq(headSeq),
  .retireFire(retireFire), .grantValid(grantValid), .grantTid(grantTid)
);

// File: tb/commit_thread_select_bench.sv
module commit_thread_select_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] policySel = '0;
  logic [NT*3-1:0] threadStatus = '0;
  logic [NT-1:0] headReady = '0;
  logic [NT-1:0] robEmpty = '0;
  logic [NT*SW-1:0] headSeq = '0;
  logic retireFire = 1'b0;
  logic grantValid;
  logic [1:0] grantTid;
  logic oneValid;
  logic oneTid;

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_thread_select #(.NUM_THREADS(NT), .SEQ_W(SW)) u_commit_thread_select (
    .clk(clk), .rstN(rstN), .policySel(policySel), .threadStatus(threadStatus),
    .headReady(headReady), .robEmpty(robEmpty), .headSeq(headSeq),
    .retireFire(retireFire), .grantValid(grantValid), .grantTid(grantTid)
  );

  commit_thread_select #(.NUM_THREADS(1), .SEQ_W(SW)) u_commit_thread_select_one (
    .clk(clk), .rstN(rstN), .policySel(policySel), .threadStatus(threadStatus[2:0]),
    .headReady(headReady[0]), .robEmpty(robEmpty[0]), .headSeq(headSeq[SW-1:0]),
    .retireFire(retireFire), .grantValid(oneValid), .grantTid(oneTid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int pol;
  int st[NT];
  bit rdy[NT];
  bit emp[NT];
  int sq[NT];
  int prio[$];

  function automatic bit elig(int code);
    return code >= 0 && code <= 2;
  endfunction

  function automatic void model(output bit v, output int tid);
    v = 0; tid = 0;
    if (pol == 3) return;
    if (pol == 1) begin
      foreach (prio[i]) begin
        if (elig(st[prio[i]]) && rdy[prio[i]]) begin
          v = 1; tid = prio[i]; return;
        end
      end
    end else begin
      int best = 0;
      for (int t = 0; t < NT; t++) begin
        if (elig(st[t]) && rdy[t] && !emp[t] && (!v || sq[t] < best)) begin
          v = 1; tid = t; best = sq[t];
        end
      end
    end
  endfunction

  task automatic check(string tag, int act_v, int act_t, int exp_v, int exp_t);
    checks++;
    if (act_v != exp_v || act_t != exp_t) begin
      fails++;
      $display("FAIL %s: valid=%0d tid=%0d expected valid=%0d tid=%0d",
               tag, act_v, act_t, exp_v, exp_t);
    end
  endtask

  // drive, check combinational result (R9), then advance a clock
  task automatic step(string tag, bit fire);
    bit ev; int et; bit ov;
    policySel = 2'(pol);
    for (int t = 0; t < NT; t++) begin
      threadStatus[t*3 +: 3] = 3'(st[t]);
      headReady[t] = rdy[t];
      robEmpty[t] = emp[t];
      headSeq[t*SW +: SW] = SW'(sq[t]);
    end
    retireFire = fire;
    #1;
    model(ev, et);
    check(tag, grantValid, grantTid, ev, et);
    ov = (pol != 3) && elig(st[0]);
    check({tag, " R6 single"}, oneValid, oneTid, ov, 0);
    @(posedge clk);
    if (fire && ev && pol == 1) begin
      foreach (prio[i]) if (prio[i] == et) begin prio.delete(i); break; end
      prio.push_back(et);
    end
    @(negedge clk);
  endtask

  task automatic setAll(int s, bit r, bit e);
    for (int t = 0; t < NT; t++) begin st[t] = s; rdy[t] = r; emp[t] = e; sq[t] = 10 + t; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: valid=0 tid=0 expected valid=1 tid=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lcg = 32'h1234;
    for (int t = 0; t < NT; t++) prio.push_back(t);
    pol = 1;
    setAll(0, 1, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R7: reset order puts thread 0 first
    step("R7 reset order", 0);
    // R4: no fire keeps list
    step("R4 no fire", 0);
    // R4: rotation 0,1,2,3,0
    for (int k = 0; k < 5; k++) step("R4 rotate", 1);
    // R3: only thread 2 and 3 ready; scan skips
    rdy[0] = 0; rdy[1] = 0;
    step("R3 partial ready", 1);
    step("R3 partial ready", 1);
    setAll(0, 1, 0);
    // R2: each code alone on thread 0 in round-robin
    for (int c = 0; c < 8; c++) begin
      setAll(3, 1, 0); st[0] = c;
      step("R2 status code", 0);
    end
    // R5: seq against thread order
    pol = 2; setAll(1, 1, 0);
    sq[0] = 40; sq[1] = 9; sq[2] = 30; sq[3] = 5;
    step("R5 oldest", 0);
    emp[3] = 1;
    step("R5 empty skipped", 0);
    sq[0] = 9; step("R5 tie lower id", 0);
    // R1: aggressive matches oldest-ready
    pol = 0; step("R1 aggressive", 0);
    pol = 3; step("R1 reserved", 0);
    // R8: none qualifies
    pol = 2; setAll(4, 1, 0); step("R8 none", 0);
    // R6: single thread not ready, empty, eligible
    setAll(2, 0, 1); step("R6 status only", 0);
    st[0] = 3; step("R6 trap blocks", 0);
    // mixed
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 1103515245 + 12345;
      pol = (lcg >>> 16) & 3;
      for (int t = 0; t < NT; t++) begin
        lcg = lcg * 1103515245 + 12345;
        st[t] = ((lcg >>> 16) & 32'h7fff) % 5;
        rdy[t] = ((lcg >>> 20) & 3) != 0;
        emp[t] = ((lcg >>> 23) & 7) == 0;
        sq[t] = (lcg >>> 25) & 7;
      end
      lcg = lcg * 1103515245 + 12345;
      step(pol == 1 ? "R3 R4 mixed" : "R5 mixed", ((lcg >>> 18) & 1) == 1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule